// File: doc/BRIEF.md
# Space-Vector PWM Leg Sequencer

This block drives the three legs of a two-level, three-phase voltage-source inverter by space-vector modulation. Once per switching period it takes a reference made of an angle, a modulation index and a period length in clock cycles. It finds the 60-degree sector that holds the angle and picks the two active vectors that bound that sector. A sine table and one product per vector give the dwell time of each vector. The period is then played out as a symmetric pattern of seven segments.

Every period opens and closes on the all-low zero vector. A converter upstream can therefore switch while no current flows, and no separate synchronizing circuit is needed. Each leg bit commands the upper switch of its leg, and the lower switch takes the complement. Dead time is added outside this block.

The reference enters on a valid/ready handshake. `ref_ready` depends only on internal state and is high for one cycle per period. A reference counts as taken on a rising edge where `ref_valid` and `ref_ready` are both high. If `ref_valid` is low at that edge, nothing is taken and the block plays the same reference again. No back-pressure acts on the leg outputs.

Top module: `svpwm_mod`

## Requirements
- R1: While `rst_n` is low, `leg_cmd` is 000 and `period_start` is 0. The stored reference resets to angle 0, index 0 and period 0. The first period starts on the first rising edge after reset is released.
- R2: `ref_ready` is high only in the last cycle of each period, and in the cycle before the first period after reset. The pins are taken on that edge when `ref_valid` is high. When `ref_valid` is low, the previously stored reference is replayed.
- R3: `ref_angle` counts in steps of 60/256 degrees. Values 1536 to 2047 are first reduced by 1536. Sector s is the reduced value divided by 256, and the in-sector step k is the remainder.
- R4: The active vectors, written as {leg a, leg b, leg c}, are V0=100, V1=110, V2=010, V3=011, V4=001 and V5=101, in counter-clockwise order. Sector s lies between the start vector V[s] and the end vector V[(s+1) mod 6].
- R5: The index m counts in units of 1/4096, and values above 3547 are treated as 3547. Let S(j) = round(32768·sin(j·60°/256)) and let P be the effective period. The start vector dwells floor(P·m·S(256−k)/2^27) cycles and the end vector dwells floor(P·m·S(k)/2^27) cycles. Their sum is always below P.
- R6: The zero time is T0 = P minus both dwells. The leading 000 segment lasts floor(T0/4) cycles. The middle 111 segment lasts T0 − floor(T0/2) cycles. The closing 000 segment lasts floor(T0/2) − floor(T0/4) cycles.
- R7: A period runs 000, F, G, 111, G, F, 000 and lasts exactly P cycles. In even sectors F is the start vector and G the end vector. In odd sectors F is the end vector and G the start vector. Each active dwell T is split into floor(T/2) cycles for its first appearance and the rest for its second. `leg_cmd` holds steady inside a segment.
- R8: `period_start` is high in the first cycle of each period only. `leg_cmd` is 000 in that cycle and in the last cycle of every period.
- R9: Segments of zero length are skipped. When both active dwells are at least 2 cycles, every change of `leg_cmd` flips exactly one leg.
- R10: An index of 0 gives 000, 111, 000 with no active vector. A step of k=0 gives no end-vector time.
- R11: A `period_len` below 32 is treated as 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_valid | input | 1 | Reference on the pins is valid |
| ref_ready | output | 1 | Reference taken on this edge (last cycle of the period) |
| ref_angle | input | 11 | Reference angle, 60/256-degree steps |
| ref_index | input | 12 | Modulation index, 1/4096 units |
| period_len | input | 16 | Switching period in clock cycles |
| leg_cmd | output | 3 | Upper-switch commands {a, b, c} |
| period_start | output | 1 | First cycle of a switching period |

## Verification
A wrong segment length or a bad next-segment choice moves the leg transitions within the same period. It also shifts `period_start` and `ref_ready` away from a period of exactly P cycles, so every later period is misaligned too. A wrong sector, vector order or dwell value shows up at the very next leg transition after the reference is taken. Sectors and angles are compared cycle by cycle against an independent model over whole periods. The clamps, the angle wrap, the zero-index case and a replay with `ref_valid` low each show up within one period.

// File: rtl/svpwm_pkg.sv
package svpwm_pkg;

  typedef enum logic [2:0] {
    SEG_Z0A = 3'd0,
    SEG_FA  = 3'd1,
    SEG_SA  = 3'd2,
    SEG_Z7  = 3'd3,
    SEG_SB  = 3'd4,
    SEG_FB  = 3'd5,
    SEG_Z0B = 3'd6
  } seg_e;

  localparam int NUM_SEG = 7;

  // Counter-clockwise active vectors, bit 2 = leg a.
  function automatic logic [2:0] active_vec(input logic [2:0] idx);
    logic [2:0] v;
    case (idx)
      3'd0:    v = 3'b100;
      3'd1:    v = 3'b110;
      3'd2:    v = 3'b010;
      3'd3:    v = 3'b011;
      3'd4:    v = 3'b001;
      default: v = 3'b101;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/svpwm_sector.sv
module svpwm_sector #(
  parameter int SEC_BITS = 8,
  localparam int ANG_W   = SEC_BITS + 3
) (
  input  logic [ANG_W-1:0]    angle_i,
  output logic [2:0]          sector_o,
  output logic [SEC_BITS-1:0] frac_o
);
  localparam logic [ANG_W-1:0] SPAN = ANG_W'(6 << SEC_BITS);

  logic [ANG_W-1:0] wrapped;

  always_comb begin
    wrapped  = (angle_i >= SPAN) ? angle_i - SPAN : angle_i;
    sector_o = wrapped[ANG_W-1:SEC_BITS];
    frac_o   = wrapped[SEC_BITS-1:0];
  end
endmodule

// File: rtl/svpwm_dwell.sv
module svpwm_dwell #(
  parameter int SEC_BITS = 8,
  parameter int MI_W     = 12,
  parameter int PER_W    = 16,
  parameter int SIN_W    = 16,
  parameter int PER_MIN  = 32
) (
  input  logic [SEC_BITS-1:0] frac_i,
  input  logic [MI_W-1:0]     index_i,
  input  logic [PER_W-1:0]    period_i,
  output logic [PER_W-1:0]    t_start_o,
  output logic [PER_W-1:0]    t_end_o,
  output logic [PER_W-1:0]    period_o
);
  localparam int  N      = 1 << SEC_BITS;
  localparam int  MI_MAX = (866 << MI_W) / 1000;
  localparam int  PW     = PER_W + MI_W + SIN_W;
  localparam int  SH     = MI_W + SIN_W - 1;
  localparam real PI     = 3.141592653589793;
  localparam real AMP    = real'(1 << (SIN_W - 1));

  // One sector of sine, entry j at j*60/N degrees.
  logic [SIN_W-1:0] sin_tab [0:N];
  for (genvar j = 0; j <= N; j++) begin : g_tab
    localparam int SV = $rtoi(AMP * $sin(real'(j) * PI / (3.0 * real'(N))) + 0.5);
    assign sin_tab[j] = SIN_W'(SV);
  end

  logic [SEC_BITS:0] idx_s, idx_e;
  logic [MI_W-1:0]   mi_eff;
  logic [PW-1:0]     prod_s, prod_e;

  always_comb begin
    idx_s    = (SEC_BITS+1)'(N) - {1'b0, frac_i};
    idx_e    = {1'b0, frac_i};
    mi_eff   = (int'(index_i) > MI_MAX) ? MI_W'(MI_MAX) : index_i;
    period_o = (int'(period_i) < PER_MIN) ? PER_W'(PER_MIN) : period_i;
    prod_s   = PW'(period_o) * PW'(mi_eff) * PW'(sin_tab[idx_s]);
    prod_e   = PW'(period_o) * PW'(mi_eff) * PW'(sin_tab[idx_e]);
    t_start_o = PER_W'(prod_s >> SH);
    t_end_o   = PER_W'(prod_e >> SH);
  end
endmodule

// File: rtl/svpwm_seq.sv
module svpwm_seq
  import svpwm_pkg::*;
#(
  parameter int PER_W = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SEG-1:0][PER_W-1:0]   seg_len_i,
  input  logic [2:0]                      vec_first_i,
  input  logic [2:0]                      vec_second_i,
  output logic                            load_o,
  output logic [2:0]                      leg_cmd_o,
  output logic                            period_start_o
);
  seg_e                          seg_q, seg_nx;
  logic [PER_W-1:0]              rem_q;
  logic [NUM_SEG-1:0][PER_W-1:0] len_q;
  logic [2:0]                    vf_q, vs_q;
  logic                          pstart_q;
  logic                          act_ok;

  assign load_o = (seg_q == SEG_Z0B) && (rem_q == PER_W'(1));

  // First non-empty segment after the current one; the closing zero is never empty.
  always_comb begin
    seg_nx = SEG_Z0B;
    for (int j = NUM_SEG - 2; j >= 1; j--) begin
      if (j > int'(seg_q) && len_q[j] != '0) seg_nx = seg_e'(3'(j));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q    <= SEG_Z0B;
      rem_q    <= PER_W'(1);
      len_q    <= '0;
      vf_q     <= 3'b000;
      vs_q     <= 3'b000;
      pstart_q <= 1'b0;
    end else if (load_o) begin
      seg_q    <= SEG_Z0A;
      rem_q    <= seg_len_i[0];
      len_q    <= seg_len_i;
      vf_q     <= vec_first_i;
      vs_q     <= vec_second_i;
      pstart_q <= 1'b1;
    end else if (rem_q > PER_W'(1)) begin
      rem_q    <= rem_q - PER_W'(1);
      pstart_q <= 1'b0;
    end else begin
      seg_q    <= seg_nx;
      rem_q    <= len_q[seg_nx];
      pstart_q <= 1'b0;
    end
  end

  always_comb begin
    case (seg_q)
      SEG_FA, SEG_FB: leg_cmd_o = vf_q;
      SEG_SA, SEG_SB: leg_cmd_o = vs_q;
      SEG_Z7:         leg_cmd_o = 3'b111;
      default:        leg_cmd_o = 3'b000;
    endcase
  end

  assign period_start_o = pstart_q;
  assign act_ok = (len_q[1] != '0) && (len_q[2] != '0) &&
                  (len_q[4] != '0) && (len_q[5] != '0);

  // R8: a period opens on 000 right after a 000 cycle.
  p_zero_edges_r8: assert property (@(posedge clk) disable iff (!rst_n)
    period_start_o |-> (leg_cmd_o == 3'b000) && ($past(leg_cmd_o) == 3'b000));

  // R2: taking a reference starts the next period.
  p_ready_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> period_start_o);

  // R7: the legs only move when a segment runs out.
  p_hold_segment_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (leg_cmd_o != $past(leg_cmd_o)) |-> ($past(rem_q) == PER_W'(1)));

  // R9: one leg per transition when all active halves are present.
  p_one_leg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((leg_cmd_o != $past(leg_cmd_o)) && act_ok) |->
      ($countones(leg_cmd_o ^ $past(leg_cmd_o)) == 1));

  // R6: the segment countdown never reaches an empty state.
  p_rem_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q != '0);
endmodule

// File: rtl/svpwm_mod.sv
module svpwm_mod
  import svpwm_pkg::*;
#(
  parameter int SEC_BITS = 8,
  parameter int MI_W     = 12,
  parameter int PER_W    = 16,
  parameter int SIN_W    = 16,
  parameter int PER_MIN  = 32,
  localparam int ANG_W   = SEC_BITS + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_valid,
  output logic             ref_ready,
  input  logic [ANG_W-1:0] ref_angle,
  input  logic [MI_W-1:0]  ref_index,
  input  logic [PER_W-1:0] period_len,
  output logic [2:0]       leg_cmd,
  output logic             period_start
);
  logic [ANG_W-1:0]    ang_q, ang_n;
  logic [MI_W-1:0]     mi_q, mi_n;
  logic [PER_W-1:0]    per_q, per_n;
  logic                take;
  logic [2:0]          sector, sector_nx;
  logic [SEC_BITS-1:0] frac;
  logic [PER_W-1:0]    t_start, t_end, p_eff;
  logic [PER_W-1:0]    t_first, t_second, t_zero;
  logic [2:0]          v_first, v_second;
  logic [NUM_SEG-1:0][PER_W-1:0] seg_len;

  assign take  = ref_valid & ref_ready;
  assign ang_n = take ? ref_angle  : ang_q;
  assign mi_n  = take ? ref_index  : mi_q;
  assign per_n = take ? period_len : per_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ang_q <= '0;
      mi_q  <= '0;
      per_q <= '0;
    end else if (ref_ready) begin
      ang_q <= ang_n;
      mi_q  <= mi_n;
      per_q <= per_n;
    end
  end

  svpwm_sector #(.SEC_BITS(SEC_BITS)) u_sector (
    .angle_i  (ang_n),
    .sector_o (sector),
    .frac_o   (frac)
  );

  svpwm_dwell #(
    .SEC_BITS(SEC_BITS), .MI_W(MI_W), .PER_W(PER_W),
    .SIN_W(SIN_W), .PER_MIN(PER_MIN)
  ) u_dwell (
    .frac_i    (frac),
    .index_i   (mi_n),
    .period_i  (per_n),
    .t_start_o (t_start),
    .t_end_o   (t_end),
    .period_o  (p_eff)
  );

  // Odd sectors start on the end vector so that each step flips one leg.
  always_comb begin
    sector_nx = (sector == 3'd5) ? 3'd0 : sector + 3'd1;
    if (sector[0]) begin
      t_first  = t_end;
      t_second = t_start;
      v_first  = active_vec(sector_nx);
      v_second = active_vec(sector);
    end else begin
      t_first  = t_start;
      t_second = t_end;
      v_first  = active_vec(sector);
      v_second = active_vec(sector_nx);
    end
    t_zero     = p_eff - t_start - t_end;
    seg_len[0] = t_zero >> 2;
    seg_len[1] = t_first >> 1;
    seg_len[2] = t_second >> 1;
    seg_len[3] = t_zero - (t_zero >> 1);
    seg_len[4] = t_second - (t_second >> 1);
    seg_len[5] = t_first - (t_first >> 1);
    seg_len[6] = (t_zero >> 1) - (t_zero >> 2);
  end

  svpwm_seq #(.PER_W(PER_W)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .seg_len_i      (seg_len),
    .vec_first_i    (v_first),
    .vec_second_i   (v_second),
    .load_o         (ref_ready),
    .leg_cmd_o      (leg_cmd),
    .period_start_o (period_start)
  );

  // R5: both dwells together leave room for zero vectors.
  p_dwell_fits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ready |-> ((PER_W+1)'(t_start) + (PER_W+1)'(t_end) < (PER_W+1)'(p_eff)));

  // R3: the reduced angle always lands in one of six sectors.
  p_sector_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ready |-> (sector < 3'd6));
endmodule

// File: tb/svpwm_mod_test.sv
module svpwm_mod_test;
  localparam int  CLK_PERIOD = 10;
  localparam real PI         = 3.141592653589793;
  localparam int  NROW       = 12;

  // {angle[38:28], index[27:16], period[15:0]}
  localparam logic [38:0] ROWS [NROW] = '{
    {11'd100,  12'd2000, 16'd64},   // R4 sector 0
    {11'd300,  12'd3000, 16'd100},  // R4 sector 1, odd order
    {11'd600,  12'd1500, 16'd80},   // sector 2
    {11'd900,  12'd3547, 16'd120},  // sector 3 at max index
    {11'd1100, 12'd4095, 16'd120},  // R5 index clamp
    {11'd1400, 12'd2500, 16'd96},   // sector 5
    {11'd1576, 12'd2200, 16'd72},   // R3 wrap
    {11'd256,  12'd2000, 16'd64},   // R10 k=0
    {11'd0,    12'd0,    16'd40},   // R10 zero index
    {11'd700,  12'd2000, 16'd10},   // R11 short period
    {11'd2047, 12'd3000, 16'd200},  // R3 top angle
    {11'd255,  12'd3500, 16'd150}   // R6 end of sector
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_valid = 1'b0;
  logic        ref_ready;
  logic [10:0] ref_angle = '0;
  logic [11:0] ref_index = '0;
  logic [15:0] period_len = '0;
  logic [2:0]  leg_cmd;
  logic        period_start;

  int n_vec = 0;
  int n_miss = 0;

  logic [2:0] exp_leg [0:1023];
  int         exp_p;
  bit         both_ok;

  always #(CLK_PERIOD/2) clk = ~clk;

  svpwm_mod uut (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_ready(ref_ready),
    .ref_angle(ref_angle), .ref_index(ref_index), .period_len(period_len),
    .leg_cmd(leg_cmd), .period_start(period_start)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_miss++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int stab(input int j);
    return $rtoi(32768.0 * $sin(real'(j) * PI / (3.0 * 256.0)) + 0.5);
  endfunction

  function automatic logic [2:0] vec(input int i);
    case (i)
      0: return 3'b100;
      1: return 3'b110;
      2: return 3'b010;
      3: return 3'b011;
      4: return 3'b001;
      default: return 3'b101;
    endcase
  endfunction

  task automatic calc(input int ang_in, input int m_in, input int per_in);
    int ang, s, k, m, p, tsv, tev, tf, tsec, t0, pos;
    int lens [7];
    logic [2:0] vf, vsec;
    logic [2:0] vecs [7];
    ang = (ang_in >= 1536) ? ang_in - 1536 : ang_in;
    s = ang / 256;
    k = ang % 256;
    m = (m_in > 3547) ? 3547 : m_in;
    p = (per_in < 32) ? 32 : per_in;
    tsv = int'((longint'(p) * longint'(m) * longint'(stab(256 - k))) >>> 27);
    tev = int'((longint'(p) * longint'(m) * longint'(stab(k))) >>> 27);
    if (s % 2 == 1) begin
      tf = tev; tsec = tsv; vf = vec((s + 1) % 6); vsec = vec(s);
    end else begin
      tf = tsv; tsec = tev; vf = vec(s); vsec = vec((s + 1) % 6);
    end
    t0 = p - tsv - tev;
    lens = '{t0/4, tf/2, tsec/2, t0 - t0/2, tsec - tsec/2, tf - tf/2, t0/2 - t0/4};
    vecs = '{3'b000, vf, vsec, 3'b111, vsec, vf, 3'b000};
    pos = 0;
    for (int g = 0; g < 7; g++)
      for (int c = 0; c < lens[g]; c++) begin
        exp_leg[pos] = vecs[g];
        pos++;
      end
    exp_p = p;
    both_ok = (tf >= 2) && (tsec >= 2);
  endtask

  // Entered just before the loading edge; leaves at the sample of the last cycle.
  task automatic run_period(input string tag);
    int bad_leg = 0, bad_ps = 0, bad_rdy = 0, multi = 0;
    int first_i = -1, act_v = 0, exp_v = 0;
    logic [2:0] prev = 3'b000;
    for (int i = 0; i < exp_p; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (leg_cmd !== exp_leg[i]) begin
        bad_leg++;
        if (first_i < 0) begin first_i = i; act_v = leg_cmd; exp_v = exp_leg[i]; end
      end
      if (period_start !== (i == 0)) bad_ps++;
      if (ref_ready !== (i == exp_p - 1)) bad_rdy++;
      if (i > 0 && both_ok && leg_cmd != prev && $countones(leg_cmd ^ prev) != 1) multi++;
      prev = leg_cmd;
    end
    check(bad_leg == 0, {tag, " R7 leg pattern (first bad cycle ", $sformatf("%0d", first_i), ")"},
          act_v, exp_v);
    check(bad_ps == 0, {tag, " R8 period_start placement, bad cycles"}, bad_ps, 0);
    check(bad_rdy == 0, {tag, " R2 ref_ready placement, bad cycles"}, bad_rdy, 0);
    check(multi == 0, {tag, " R9 multi-leg transitions"}, multi, 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_miss++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(leg_cmd == 3'b000, "R1 legs in reset", leg_cmd, 0);
    check(period_start == 1'b0, "R1 period_start in reset", period_start, 0);

    for (int r = 0; r < NROW; r++) begin
      ref_angle  = ROWS[r][38:28];
      ref_index  = ROWS[r][27:16];
      period_len = ROWS[r][15:0];
      ref_valid  = 1'b1;
      if (r == 0) rst_n = 1'b1;
      calc(int'(ROWS[r][38:28]), int'(ROWS[r][27:16]), int'(ROWS[r][15:0]));
      run_period($sformatf("row %0d", r));
    end

    // R2: valid low replays the last taken reference (row 11).
    ref_valid  = 1'b0;
    ref_angle  = ROWS[0][38:28];
    ref_index  = ROWS[0][27:16];
    period_len = ROWS[0][15:0];
    run_period("R2 replay");

    // R1: reset mid-run restores the default reference.
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(leg_cmd == 3'b000, "R1 legs after mid-run reset", leg_cmd, 0);
    check(period_start == 1'b0, "R1 period_start after mid-run reset", period_start, 0);
    rst_n = 1'b1;
    calc(0, 0, 0);
    run_period("R1 default reference");

    finish_run();
  end
endmodule